// File: doc/BRIEF.md
# Serial Clock and Chip-Select Timing Generator

This block sits between the transfer engine of a serial flash master and its bit shifter. From a fast reference clock it derives the serial clock. It also sequences the chip-select lines around each transfer. The divider ratio, the clock polarity and phase, the chip-select field and four delay counts (all in reference cycles) are captured into a shadow copy. That copy is loaded only while the block is disabled and no transfer is running, so the timing cannot change part-way through a transfer.

The transfer engine issues a one-cycle start request and marks the final byte with a last-byte request. The block then performs these steps in order:
- It lowers the selected chip-select line.
- It waits the setup delay.
- It runs 16 serial clock transitions per byte and marks each transition as a sample edge or a shift edge for the shifter.
- It waits the hold delay after the final transition.
- It raises chip select.

A minimum chip-select high time is enforced before the next transfer. A longer device-switch time applies instead when the next transfer addresses different chip-select lines than the previous one. Chip select leaves the block either as an index turned into one active-low line, or as the raw field for an external decoder.

Top module: `spi_sclk_cs_timer`

## Requirements
- R1: Every serial clock half-period lasts exactly `baud`+1 reference cycles, where `baud` is 4 bits wide (division ratio 2 to 32). A transfer makes exactly 16 transitions per byte, with no pause between bytes.
- R2: Whenever all chip-select lines are high, `sclk` rests at the captured polarity level. `cpol`=0 means low and 1 means high.
- R3: `sample_stb` and `shift_stb` are high for one cycle, in the same cycle that `sclk` changes, and never otherwise. With `cpha`=0, `sample_stb` marks the leading transitions (1st, 3rd, ... of each byte) and `shift_stb` the trailing ones. With `cpha`=1 the two are swapped.
- R4: With `cs_decode`=0, the two low bits of `cs_sel` form an index n, and `cs_n` carries a single low line at bit n (n=0 gives 1110, n=3 gives 0111).
- R5: With `cs_decode`=1, `cs_n` carries `cs_sel` unchanged for the whole transfer.
- R6: The first `sclk` transition comes exactly `dly_setup`+`baud`+2 reference cycles after chip select falls.
- R7: Chip select rises exactly `dly_hold`+1 cycles after the final transition. The final byte is the one during which `last_byte` was seen high after the transfer started. Without that request another byte follows.
- R8: When a start is pending for the same chip-select pattern as the previous transfer, chip select falls exactly `dly_gap`+1 cycles after it rose.
- R9: When the chip-select pattern differs from that of the previous transfer, the high time before the new transfer is `dly_dev`+1 cycles instead.
- R10: A start request is taken only while `enable` is high. A request made while disabled is dropped and never starts a transfer later.
- R11: Configuration inputs are captured only while `enable` is low and no transfer is in progress. Changes made while enabled have no effect on divider, polarity, phase or chip select.
- R12: After reset `cs_n`=1111, `sclk`=0, both strobes are 0 and `idle`=1. `idle` is high only while chip select is high and the required high time has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Operation enable; configuration is captured while low |
| baud | input | 4 | Divider field; half-period is baud+1 cycles |
| cpol | input | 1 | Serial clock rest level |
| cpha | input | 1 | Selects the trailing transition as the sample edge |
| cs_sel | input | 4 | Chip-select index or raw pattern |
| cs_decode | input | 1 | 1: pass cs_sel raw; 0: index to one active-low line |
| dly_setup | input | 8 | Chip-select-low to first transition delay |
| dly_hold | input | 8 | Final transition to chip-select-high delay |
| dly_dev | input | 8 | High time before a transfer to another pattern |
| dly_gap | input | 8 | High time between transfers to the same pattern |
| xfer_start | input | 1 | Start request pulse |
| last_byte | input | 1 | Marks the current byte as the final one |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip-select lines |
| sample_stb | output | 1 | Sample edge strobe for the shifter |
| shift_stb | output | 1 | Shift edge strobe for the shifter |
| idle | output | 1 | No transfer active and all delays expired |

## Verification
A wrong divider count or transition counter shows up within the first byte, as an uneven half-period or a byte that does not have 16 transitions. The bench measures every interval between transitions. A wrong sequencer delay load moves the first transition or the chip-select rise by at least one cycle, and the bench measures these against the reference-cycle counter. A wrong record of the previous pattern, or a wrong gap counter, changes the measured high time between two back-to-back transfers. A shadow that loads while enabled shows in the half-period and rest level of the very next transfer.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_HOLD  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/spi_tmg_cfg.sv
module spi_tmg_cfg #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] baud_in,
  input  logic             cpol_in,
  input  logic             cpha_in,
  input  logic [CS_W-1:0]  sel_in,
  input  logic             dec_in,
  input  logic [DLY_W-1:0] setup_in,
  input  logic [DLY_W-1:0] hold_in,
  input  logic [DLY_W-1:0] dev_in,
  input  logic [DLY_W-1:0] gap_in,
  output logic [DIV_W-1:0] baud_q,
  output logic             cpol_q,
  output logic             cpha_q,
  output logic             dec_q,
  output logic [CS_W-1:0]  cs_code,
  output logic [DLY_W-1:0] setup_q,
  output logic [DLY_W-1:0] hold_q,
  output logic [DLY_W-1:0] dev_q,
  output logic [DLY_W-1:0] gap_q
);

  localparam int IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1;

  logic [CS_W-1:0] sel_q;

  // Turn the captured field into the active-low line pattern.
  function automatic logic [CS_W-1:0] cs_lines(input logic [CS_W-1:0] sel,
                                               input logic dec);
    logic [CS_W-1:0] hot;
    hot = '0;
    hot[sel[IDX_W-1:0]] = 1'b1;
    return dec ? sel : ~hot;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q  <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      sel_q   <= '0;
      dec_q   <= 1'b0;
      setup_q <= '0;
      hold_q  <= '0;
      dev_q   <= '0;
      gap_q   <= '0;
    end else if (load) begin
      baud_q  <= baud_in;
      cpol_q  <= cpol_in;
      cpha_q  <= cpha_in;
      sel_q   <= sel_in;
      dec_q   <= dec_in;
      setup_q <= setup_in;
      hold_q  <= hold_in;
      dev_q   <= dev_in;
      gap_q   <= gap_in;
    end
  end

  assign cs_code = cs_lines(sel_q, dec_q);

endmodule

// File: rtl/spi_tmg_clkgen.sv
module spi_tmg_clkgen #(
  parameter int DIV_W = 4,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] baud,
  input  logic             cpol,
  input  logic             cpha,
  output logic             byte_end,
  output logic             sclk,
  output logic             sample_stb,
  output logic             shift_stb
);

  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  logic [DIV_W-1:0] dcnt;
  logic [EW-1:0]    ecnt;
  logic             tick;

  // Even-numbered transitions lead; phase 0 samples on them.
  function automatic logic is_sample(input logic edge_lsb, input logic ph);
    return edge_lsb == ph;
  endfunction

  assign tick     = run && (dcnt == baud);
  assign byte_end = tick && (ecnt == EW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt       <= '0;
      ecnt       <= '0;
      sclk       <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else if (!run) begin
      dcnt       <= '0;
      ecnt       <= '0;
      sclk       <= cpol;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      sample_stb <= tick && is_sample(ecnt[0], cpha);
      shift_stb  <= tick && !is_sample(ecnt[0], cpha);
      if (tick) begin
        dcnt <= '0;
        ecnt <= (ecnt == EW'(EDGES - 1)) ? '0 : ecnt + 1'b1;
        sclk <= ~sclk;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  p_strobe_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> (sclk != $past(sclk)));

  p_no_edge_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !run) |-> $stable(sclk) || (sclk == $past(cpol)));

endmodule

// File: rtl/spi_tmg_seq.sv
module spi_tmg_seq
  import spi_tmg_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int CS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             xfer_start,
  input  logic             last_byte,
  input  logic             byte_end,
  input  logic [CS_W-1:0]  cs_code,
  input  logic [DLY_W-1:0] setup_q,
  input  logic [DLY_W-1:0] hold_q,
  input  logic [DLY_W-1:0] dev_q,
  input  logic [DLY_W-1:0] gap_q,
  output logic             run,
  output logic             at_rest,
  output logic             idle,
  output logic [CS_W-1:0]  cs_n
);

  seq_state_t       st;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] hi_cnt;
  logic [CS_W-1:0]  prev_code;
  logic             pend;
  logic             last_q;
  logic [DLY_W-1:0] need;
  logic             gap_ok;
  logic             launch;
  logic             finish;

  // Longer separation when the next transfer addresses other lines.
  function automatic logic [DLY_W-1:0] high_time(input logic [CS_W-1:0] nxt,
                                                 input logic [CS_W-1:0] prv,
                                                 input logic [DLY_W-1:0] dev,
                                                 input logic [DLY_W-1:0] gap);
    return (nxt != prv) ? dev : gap;
  endfunction

  assign need    = high_time(cs_code, prev_code, dev_q, gap_q);
  assign gap_ok  = hi_cnt >= need;
  assign at_rest = (st == SEQ_IDLE);
  assign run     = (st == SEQ_RUN);
  assign idle    = at_rest && gap_ok;
  assign launch  = at_rest && pend && enable && gap_ok;
  assign finish  = byte_end && (last_q || last_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      cnt       <= '0;
      hi_cnt    <= '1;
      prev_code <= '1;
      pend      <= 1'b0;
      last_q    <= 1'b0;
      cs_n      <= '1;
    end else begin
      pend <= (pend && !launch) || (xfer_start && enable);
      if ((st == SEQ_SETUP || st == SEQ_RUN) && last_byte) last_q <= 1'b1;
      case (st)
        SEQ_IDLE: begin
          if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
          if (launch) begin
            st        <= SEQ_SETUP;
            cnt       <= setup_q;
            cs_n      <= cs_code;
            prev_code <= cs_code;
            last_q    <= 1'b0;
          end
        end
        SEQ_SETUP: begin
          if (cnt == '0) st <= SEQ_RUN;
          else           cnt <= cnt - 1'b1;
        end
        SEQ_RUN: begin
          if (finish) begin
            st  <= SEQ_HOLD;
            cnt <= hold_q;
          end
        end
        default: begin
          if (cnt == '0) begin
            st     <= SEQ_IDLE;
            cs_n   <= '1;
            hi_cnt <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  p_idle_cs_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (&cs_n));

  p_no_clock_in_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_SETUP) |-> !byte_end);

  p_cs_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !(&$past(cs_n))) |-> $stable(cs_n));

endmodule

// File: rtl/spi_sclk_cs_timer.sv
module spi_sclk_cs_timer #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] baud,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [CS_W-1:0]  cs_sel,
  input  logic             cs_decode,
  input  logic [DLY_W-1:0] dly_setup,
  input  logic [DLY_W-1:0] dly_hold,
  input  logic [DLY_W-1:0] dly_dev,
  input  logic [DLY_W-1:0] dly_gap,
  input  logic             xfer_start,
  input  logic             last_byte,
  output logic             sclk,
  output logic [CS_W-1:0]  cs_n,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             idle
);

  logic [DIV_W-1:0] baud_q;
  logic             cpol_q;
  logic             cpha_q;
  logic             dec_q;
  logic [CS_W-1:0]  cs_code;
  logic [DLY_W-1:0] setup_q, hold_q, dev_q, gap_q;
  logic             run;
  logic             at_rest;
  logic             byte_end;
  logic             cfg_load;

  assign cfg_load = !enable && at_rest;

  spi_tmg_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_W(CS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .baud_in(baud), .cpol_in(cpol), .cpha_in(cpha),
    .sel_in(cs_sel), .dec_in(cs_decode),
    .setup_in(dly_setup), .hold_in(dly_hold), .dev_in(dly_dev), .gap_in(dly_gap),
    .baud_q(baud_q), .cpol_q(cpol_q), .cpha_q(cpha_q), .dec_q(dec_q),
    .cs_code(cs_code),
    .setup_q(setup_q), .hold_q(hold_q), .dev_q(dev_q), .gap_q(gap_q)
  );

  spi_tmg_clkgen #(.DIV_W(DIV_W), .BITS(BITS)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .baud(baud_q),
    .cpol(cpol_q), .cpha(cpha_q), .byte_end(byte_end),
    .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  spi_tmg_seq #(.DLY_W(DLY_W), .CS_W(CS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .xfer_start(xfer_start), .last_byte(last_byte), .byte_end(byte_end),
    .cs_code(cs_code), .setup_q(setup_q), .hold_q(hold_q),
    .dev_q(dev_q), .gap_q(gap_q),
    .run(run), .at_rest(at_rest), .idle(idle), .cs_n(cs_n)
  );

  p_rest_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cs_n) && (&$past(cs_n))) |-> (sclk == $past(cpol_q)));

  p_onecold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_q && !(&cs_n)) |-> ($countones(~cs_n) == 1));

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> ($stable(baud_q) && $stable(cpol_q) && $stable(cs_code)));

endmodule

// File: tb/spi_sclk_cs_timer_tb.sv
module spi_sclk_cs_timer_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] baud = '0;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic [3:0] cs_sel = '0;
  logic       cs_decode = 1'b0;
  logic [7:0] dly_setup = '0, dly_hold = '0, dly_dev = '0, dly_gap = '0;
  logic       xfer_start = 1'b0, last_byte = 1'b0;
  logic       sclk, sample_stb, shift_stb, idle;
  logic [3:0] cs_n;

  spi_sclk_cs_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .baud(baud), .cpol(cpol),
    .cpha(cpha), .cs_sel(cs_sel), .cs_decode(cs_decode),
    .dly_setup(dly_setup), .dly_hold(dly_hold), .dly_dev(dly_dev),
    .dly_gap(dly_gap), .xfer_start(xfer_start), .last_byte(last_byte),
    .sclk(sclk), .cs_n(cs_n), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .idle(idle)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  // Port monitor: transfer boundaries, transition times, strobe pattern.
  int edge_t[64];
  int n_edges = 0, t_fall = 0, t_rise = 0, rise_cnt = 0, fall_cnt = 0;
  int last_gap = 0, stb_bad = 0;
  logic [3:0] cur_code = '1, prev_cs = '1;
  logic prev_sclk = 1'b0;
  bit exp_cpha = 0;

  always @(negedge clk) if (rst_n) begin
    if ((&prev_cs) && !(&cs_n)) begin
      t_fall = cyc; n_edges = 0; cur_code = cs_n; fall_cnt++;
      if (rise_cnt > 0) last_gap = cyc - t_rise;
    end
    if (!(&prev_cs) && (&cs_n)) begin
      t_rise = cyc; rise_cnt++;
    end
    if (sclk !== prev_sclk && !(&prev_cs && &cs_n)) begin
      bit smp;
      smp = ((n_edges % 2) == 0) ? !exp_cpha : exp_cpha;
      if (sample_stb !== smp || shift_stb !== !smp) stb_bad++;
      if (n_edges < 64) edge_t[n_edges] = cyc;
      n_edges++;
    end else if (sclk === prev_sclk && (sample_stb || shift_stb)) begin
      stb_bad++;
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic configure(input logic [3:0] b, input logic pl, input logic ph,
                           input logic [3:0] sel, input logic dec,
                           input int ds, input int dh, input int dd, input int dg);
    step();
    enable = 0;
    baud = b; cpol = pl; cpha = ph; cs_sel = sel; cs_decode = dec;
    dly_setup = 8'(ds); dly_hold = 8'(dh); dly_dev = 8'(dd); dly_gap = 8'(dg);
    repeat (3) step();
    enable = 1;
    step();
  endtask

  task automatic wait_rise(input int r0);
    for (int w = 0; w < 20000 && rise_cnt == r0; w++) step();
  endtask

  task automatic xfer(input int nbytes, input logic [3:0] code, input string creq,
                      input int h, input int d, input int hold,
                      input logic pl, input logic ph);
    int r0, bad;
    r0 = rise_cnt; exp_cpha = ph; stb_bad = 0;
    last_byte = (nbytes == 1);
    xfer_start = 1; step(); xfer_start = 0;
    for (int w = 0; w < 20000 && rise_cnt == r0; w++) begin
      if (nbytes > 1 && n_edges >= 16 * (nbytes - 1) + 1) last_byte = 1;
      step();
    end
    last_byte = 0;
    chk(cur_code == code, creq, "chip-select pattern", cur_code, code);
    chk(n_edges == 16 * nbytes, "R1", "transition count", n_edges, 16 * nbytes);
    chk(edge_t[0] - t_fall == d + h + 1, "R6", "setup interval",
        edge_t[0] - t_fall, d + h + 1);
    bad = 0;
    for (int i = 1; i < n_edges && i < 64; i++)
      if (edge_t[i] - edge_t[i-1] != h) bad++;
    chk(bad == 0, "R1", "uneven half-periods", bad, 0);
    if (n_edges > 0 && n_edges <= 64)
      chk(t_rise - edge_t[n_edges-1] == hold + 1, "R7", "hold interval",
          t_rise - edge_t[n_edges-1], hold + 1);
    chk(stb_bad == 0, "R3", "strobe mismatches", stb_bad, 0);
    repeat (2) step();
    chk(sclk == pl, "R2", "rest level", sclk, pl);
  endtask

  task automatic t_reset();
    chk(cs_n == 4'b1111, "R12", "reset cs_n", cs_n, 15);
    chk(sclk == 1'b0, "R12", "reset sclk", sclk, 0);
    chk(!sample_stb && !shift_stb, "R12", "reset strobes",
        sample_stb | shift_stb, 0);
    chk(idle == 1'b1, "R12", "reset idle", idle, 1);
  endtask

  task automatic t_mode0_fast();
    configure(4'd0, 0, 0, 4'd0, 0, 0, 0, 0, 0);
    xfer(1, 4'b1110, "R4", 1, 0, 0, 0, 0);
  endtask

  task automatic t_mode3_two_bytes();
    configure(4'd3, 1, 1, 4'd3, 0, 5, 3, 0, 0);
    xfer(2, 4'b0111, "R4", 4, 5, 3, 1, 1);
  endtask

  task automatic t_decoder_slowest();
    configure(4'd15, 0, 1, 4'b1010, 1, 2, 0, 0, 0);
    xfer(1, 4'b1010, "R5", 16, 2, 0, 0, 1);
  endtask

  task automatic t_same_device_gap();
    int r0;
    configure(4'd0, 0, 0, 4'd1, 0, 0, 0, 2, 7);
    exp_cpha = 0; last_byte = 1; r0 = rise_cnt;
    xfer_start = 1; step(); xfer_start = 0;
    for (int w = 0; w < 20000 && n_edges < 2; w++) step();
    xfer_start = 1; step(); xfer_start = 0;
    wait_rise(r0);
    chk(idle == 1'b0, "R12", "idle during high time", idle, 0);
    wait_rise(r0 + 1);
    last_byte = 0;
    chk(last_gap == 8, "R8", "same-device high time", last_gap, 8);
  endtask

  task automatic t_device_switch();
    int r0;
    configure(4'd0, 0, 0, 4'd1, 0, 0, 0, 40, 3);
    exp_cpha = 0; last_byte = 1; r0 = rise_cnt;
    xfer_start = 1; step(); xfer_start = 0;
    wait_rise(r0);
    enable = 0; cs_sel = 4'd2;
    step();
    enable = 1; xfer_start = 1;
    step();
    xfer_start = 0;
    wait_rise(r0 + 1);
    last_byte = 0;
    chk(last_gap == 41, "R9", "device-switch high time", last_gap, 41);
    chk(cur_code == 4'b1011, "R4", "switched pattern", cur_code, 11);
  endtask

  task automatic t_start_while_disabled();
    int f0;
    repeat (60) step();
    f0 = fall_cnt;
    enable = 0; step();
    xfer_start = 1; step(); xfer_start = 0;
    repeat (30) step();
    chk(fall_cnt == f0 && cs_n == 4'b1111, "R10", "start taken while disabled",
        fall_cnt - f0, 0);
    enable = 1;
    repeat (30) step();
    chk(fall_cnt == f0, "R10", "dropped start launched later", fall_cnt - f0, 0);
  endtask

  task automatic t_frozen_config();
    configure(4'd1, 0, 0, 4'd0, 0, 1, 1, 0, 0);
    baud = 4'd7; cpol = 1; cpha = 1; cs_sel = 4'd3;
    step();
    xfer(1, 4'b1110, "R11", 2, 1, 1, 0, 0);
    enable = 0;
    repeat (3) step();
    chk(sclk == 1'b1, "R11", "rest level after capture while disabled", sclk, 1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_mode0_fast();
    t_mode3_two_bytes();
    t_decoder_slowest();
    t_same_device_gap();
    t_device_switch();
    t_start_while_disabled();
    t_frozen_config();
    done = 1;
    summary();
    $finish;
  end

endmodule